// File: doc/BRIEF.md
# HD Video Line CRC Checker

This block watches a parallel HD serial-digital-video stream and checks the line CRCs embedded after each end-of-active-video marker. Each clock carries a 20-bit word pair: the luma word sits in bits [19:10] and the chroma word in bits [9:0]. A luma-driven state machine finds timing reference sequences and decodes their status word. It then marks which words feed the running CRCs and where the received CRC words arrive. There is one CRC lane per stream and per link. Each lane keeps an 18-bit running CRC, captures the two received CRC words, compares them and holds a per-stream error flag for one line.

In single-link operation every cycle belongs to one link, and only bit 0 of each flag pair is used. In dual-link operation the cycles alternate between link A and link B. Link A comes first, on the first cycle after reset. The state machine decides on link A cycles, and a registered copy of its decision steers the link B lanes one cycle later. Link A reports on flag bit 1 and link B on flag bit 0.

State machine: `ST_SCAN` is an ordinary word, and a luma 3FF moves it to `ST_GOT1`. `ST_GOT1` goes to `ST_GOT2` on 000, otherwise back to `ST_SCAN`. `ST_GOT2` goes to `ST_XYZ` on 000, otherwise back to `ST_SCAN`. `ST_XYZ` decodes the status word: with H=1 it goes to `ST_LN0`, and with H=0 it goes back to `ST_SCAN` with the active region open. From there the chain runs `ST_LN0` → `ST_LN1` → `ST_CR0` → `ST_CR1` → `ST_SCAN`.

Top module: `sdi_line_crc_chk`

## Requirements
- R1: A timing reference sequence is detected on luma bits [19:10] as 3FF, 000, 000 followed by a status word. A failed match returns to scanning. After a status word with H=1, the next two words are line-number words and the two after those are CRC words.
- R2: The status word carries field in bit 8, vertical blanking in bit 7 and H in bit 6. `hblank`, `vblank` and `field` take these values on the clock edge that samples the status word and hold them until the next status word.
- R3: The CRC uses the generator x^18+x^5+x^4+1. Each word is processed LSB first in shift-right form: the feedback is the register's bit 0 XOR the data bit, the register shifts right, and the feedback is XORed into bits 17, 13 and 12. The register starts at zero after the status word with H=0. It covers every following word up to and including the second line-number word, so the end-of-active-video sequence is included.
- R4: The first CRC word carries CRC bits [8:0] in its bits [8:0], and the second carries CRC bits [17:9]. Bit 9 of both words is ignored. The flag is written on the edge that samples the second CRC word, while `hblank` is high.
- R5: Luma and chroma have independent flags. Both can be high together.
- R6: A flag changes only at a CRC check. It holds through the next line and drops when that line's check passes.
- R7: A synchronous active-high `rst` clears all flags and blanking outputs. No flag is written until a status word with H=0 has been seen after reset.
- R8: With `dual_link` low, bit 0 of `crc_err_y` and of `crc_err_c` reports the single link, and bit 1 stays 0.
- R9: With `dual_link` high, cycles alternate link A then link B, starting on the first edge after reset. Bit 1 reports link A and bit 0 reports link B. `dual_link` changes only while `rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| dual_link | input | 1 | 1 = two links interleaved cycle by cycle |
| din | input | 20 | Luma word [19:10], chroma word [9:0] |
| hblank | output | 1 | H bit of the last status word |
| vblank | output | 1 | Vertical-blanking bit of the last status word |
| field | output | 1 | Field bit of the last status word |
| crc_err_y | output | 2 | Luma CRC error flags, mapped as R8/R9 |
| crc_err_c | output | 2 | Chroma CRC error flags, mapped as R8/R9 |

## Verification
The assertions assume well-formed lines. Reserved values 3FF and 000 appear in a run only inside a timing reference sequence. Every end-of-active-video marker is followed by its two line-number words and two CRC words. In dual-link mode the two links stay pairwise aligned. The stimulus builds every line from the same template: blanking, start marker, active words kept between 004 and 3EB, end marker, line number and CRC. Corruption only alters CRC bits, and the mode changes only inside a reset pulse followed by one pad cycle that keeps link A on even cycles.

// File: rtl/sdi_crc_pkg.sv
package sdi_crc_pkg;
    localparam int WORD_W   = 10;
    localparam int CRC_W    = 18;
    localparam int HALF_W   = CRC_W / 2;
    localparam logic [CRC_W-1:0] CRC_MASK = 18'h23000;
    localparam int N_LINKS  = 2;
    localparam int N_STREAM = 2;

    typedef enum logic [2:0] {
        ST_SCAN, ST_GOT1, ST_GOT2, ST_XYZ,
        ST_LN0,  ST_LN1,  ST_CR0,  ST_CR1
    } trs_state_t;

    typedef struct packed {
        logic cov;
        logic clr;
        logic cap;
        logic chk;
    } lane_act_t;

    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c_in,
                                                   input logic [WORD_W-1:0] w);
        logic [CRC_W-1:0] c;
        logic fb;
        c = c_in;
        for (int i = 0; i < WORD_W; i++) begin
            fb = c[0] ^ w[i];
            c  = c >> 1;
            if (fb) c = c ^ CRC_MASK;
        end
        return c;
    endfunction
endpackage

// File: rtl/sdi_trs_fsm.sv
module sdi_trs_fsm
    import sdi_crc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic [WORD_W-1:0] luma,
    output lane_act_t         act,
    output logic              primed,
    output logic              hblank,
    output logic              vblank,
    output logic              field
);
    localparam logic [WORD_W-1:0] W_ONES = '1;
    localparam logic [WORD_W-1:0] W_ZERO = '0;
    localparam int B_H = WORD_W - 4;
    localparam int B_V = WORD_W - 3;
    localparam int B_F = WORD_W - 2;

    trs_state_t state, nxt;
    logic in_active;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_SCAN;
        else if (step) state <= nxt;
    end

    always_comb begin
        nxt = ST_SCAN;
        unique case (state)
            ST_SCAN: nxt = (luma == W_ONES) ? ST_GOT1 : ST_SCAN;
            ST_GOT1: nxt = (luma == W_ZERO) ? ST_GOT2 : ST_SCAN;
            ST_GOT2: nxt = (luma == W_ZERO) ? ST_XYZ  : ST_SCAN;
            ST_XYZ:  nxt = luma[B_H] ? ST_LN0 : ST_SCAN;
            ST_LN0:  nxt = ST_LN1;
            ST_LN1:  nxt = ST_CR0;
            ST_CR0:  nxt = ST_CR1;
            ST_CR1:  nxt = ST_SCAN;
            default: nxt = ST_SCAN;
        endcase
    end

    always_comb begin
        act.cov = in_active || (state == ST_LN0) || (state == ST_LN1);
        act.clr = (state == ST_XYZ) && !luma[B_H];
        act.cap = (state == ST_CR0);
        act.chk = (state == ST_CR1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_active <= 1'b0;
            primed    <= 1'b0;
            hblank    <= 1'b0;
            vblank    <= 1'b0;
            field     <= 1'b0;
        end else if (step && state == ST_XYZ) begin
            hblank    <= luma[B_H];
            vblank    <= luma[B_V];
            field     <= luma[B_F];
            in_active <= !luma[B_H];
            if (!luma[B_H]) primed <= 1'b1;
        end
    end

    assert_eav_to_ln_R1: assert property (@(posedge clk) disable iff (rst)
        (step && state == ST_XYZ && luma[B_H]) |=> (state == ST_LN0));

    assert_primed_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        primed |=> primed);

    assert_chk_in_hblank_R4: assert property (@(posedge clk) disable iff (rst)
        (step && act.chk) |-> hblank);
endmodule

// File: rtl/sdi_crc_lane.sv
module sdi_crc_lane
    import sdi_crc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              primed,
    input  lane_act_t         act,
    input  logic [WORD_W-1:0] word,
    output logic              err
);
    logic [CRC_W-1:0]  crc;
    logic [HALF_W-1:0] rx_lo;

    always_ff @(posedge clk) begin
        if (rst) begin
            crc   <= '0;
            rx_lo <= '0;
            err   <= 1'b0;
        end else if (en) begin
            if (act.clr)      crc <= '0;
            else if (act.cov) crc <= crc_step(crc, word);
            if (act.cap) rx_lo <= word[HALF_W-1:0];
            if (act.chk && primed) err <= ({word[HALF_W-1:0], rx_lo} != crc);
        end
    end

    assert_flag_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !(en && act.chk) |=> $stable(err));

    assert_unprimed_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !primed |-> !err);
endmodule

// File: rtl/sdi_line_crc_chk.sv
module sdi_line_crc_chk
    import sdi_crc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                dual_link,
    input  logic [2*WORD_W-1:0] din,
    output logic                hblank,
    output logic                vblank,
    output logic                field,
    output logic [1:0]          crc_err_y,
    output logic [1:0]          crc_err_c
);
    logic      phase;
    logic      step_a;
    logic      step_b;
    lane_act_t act;
    lane_act_t act_q;
    logic      primed;
    logic      err [N_LINKS][N_STREAM];

    always_ff @(posedge clk) begin
        if (rst || !dual_link) phase <= 1'b0;
        else phase <= ~phase;
    end

    assign step_a = !dual_link || !phase;
    assign step_b = dual_link && phase;

    always_ff @(posedge clk) begin
        if (rst) act_q <= '0;
        else if (step_a) act_q <= act;
    end

    sdi_trs_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .step   (step_a),
        .luma   (din[2*WORD_W-1:WORD_W]),
        .act    (act),
        .primed (primed),
        .hblank (hblank),
        .vblank (vblank),
        .field  (field)
    );

    for (genvar k = 0; k < N_LINKS; k++) begin : g_link
        for (genvar s = 0; s < N_STREAM; s++) begin : g_stream
            sdi_crc_lane u_lane (
                .clk    (clk),
                .rst    (rst),
                .en     ((k == 0) ? step_a : step_b),
                .primed (primed),
                .act    ((k == 0) ? act : act_q),
                .word   (din[s*WORD_W +: WORD_W]),
                .err    (err[k][s])
            );
        end
    end

    // stream index 1 = luma, 0 = chroma; link 0 = A, 1 = B
    assign crc_err_y = dual_link ? {err[0][1], err[1][1]} : {1'b0, err[0][1]};
    assign crc_err_c = dual_link ? {err[0][0], err[1][0]} : {1'b0, err[0][0]};

    assert_phase_toggle_R9: assert property (@(posedge clk) disable iff (rst)
        dual_link |=> (phase != $past(phase)));
endmodule

// File: tb/sim_sdi_line_crc_chk.sv
`timescale 1ns/1ps
module sim_sdi_line_crc_chk;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dual_link = 1'b0;
    logic [19:0] din = '0;
    logic        hblank, vblank, field;
    logic [1:0]  crc_err_y, crc_err_c;

    int n_cmp = 0;
    int n_bad = 0;

    logic [17:0] bcrc [4];
    logic [1:0]  last_ey = 2'b00;
    logic [1:0]  last_ec = 2'b00;

    logic [6:0]  exp_q [$];
    string       req_q [$];
    event        ev;

    always #4 clk = ~clk;

    sdi_line_crc_chk u0 (
        .clk(clk), .rst(rst), .dual_link(dual_link), .din(din),
        .hblank(hblank), .vblank(vblank), .field(field),
        .crc_err_y(crc_err_y), .crc_err_c(crc_err_c)
    );

    function automatic logic [17:0] ref_crc(input logic [17:0] c0, input logic [9:0] w);
        logic [17:0] c;
        logic b;
        c = c0;
        for (int i = 0; i < 10; i++) begin
            b = c[0] ^ w[i];
            c = {b, c[17:1]};
            c[13] = c[13] ^ b;
            c[12] = c[12] ^ b;
        end
        return c;
    endfunction

    task automatic tick(input logic [9:0] y, input logic [9:0] c);
        @(negedge clk);
        din = {y, c};
    endtask

    task automatic put(input logic [9:0] ya, input logic [9:0] ca,
                       input logic [9:0] yb, input logic [9:0] cb, input bit acc);
        if (acc) begin
            bcrc[0] = ref_crc(bcrc[0], ya);
            bcrc[1] = ref_crc(bcrc[1], ca);
            bcrc[2] = ref_crc(bcrc[2], yb);
            bcrc[3] = ref_crc(bcrc[3], cb);
        end
        tick(ya, ca);
        if (dual_link) tick(yb, cb);
    endtask

    task automatic put_same(input logic [9:0] w, input bit acc);
        put(w, w, w, w, acc);
    endtask

    task automatic expect_now(input logic [1:0] ey, input logic [1:0] ec,
                              input bit hb, input bit vb, input bit fl, input string req);
        @(posedge clk);
        #2;
        exp_q.push_back({ey, ec, hb, vb, fl});
        req_q.push_back(req);
        ->ev;
        #0;
    endtask

    initial begin
        forever begin
            @(ev);
            while (exp_q.size() > 0) begin
                logic [6:0] e;
                logic [6:0] a;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                a = {crc_err_y, crc_err_c, hblank, vblank, field};
                n_cmp++;
                if (a !== e) begin
                    n_bad++;
                    $display("FAIL %s: got y=%b c=%b h=%b v=%b f=%b, expected y=%b c=%b h=%b v=%b f=%b",
                             r, a[6:5], a[4:3], a[2], a[1], a[0],
                             e[6:5], e[4:3], e[2], e[1], e[0]);
                end
            end
        end
    end

    task automatic do_reset(input bit dual);
        @(negedge clk);
        rst = 1'b1;
        dual_link = dual;
        din = {10'h040, 10'h200};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        last_ey = 2'b00;
        last_ec = 2'b00;
        if (dual) tick(10'h040, 10'h200);
    endtask

    function automatic logic [9:0] act_word(input int seed, input int i, input int lane);
        return 10'(4 + ((seed * 41 + i * 7 + lane * 113) % 1000));
    endfunction

    function automatic logic [9:0] xyz(input bit f, input bit v, input bit h);
        return {1'b1, f, v, h, 6'h0};
    endfunction

    // bad bits: [0]=ya [1]=ca [2]=yb [3]=cb ; flip9 toggles ignored bit 9 of CRC words
    task automatic send_line(input int nact, input int seed, input bit f, input bit v,
                             input logic [3:0] bad, input bit flip9, input string req);
        logic [9:0] cw0 [4];
        logic [9:0] cw1 [4];
        logic [1:0] ey, ec;
        for (int i = 0; i < 4; i++) put(10'h040, 10'h200, 10'h040, 10'h200, 1'b0);
        put_same(10'h3FF, 1'b0);
        put_same(10'h000, 1'b0);
        put_same(10'h000, 1'b0);
        put_same(xyz(f, v, 1'b0), 1'b0);
        for (int k = 0; k < 4; k++) bcrc[k] = '0;
        for (int i = 0; i < nact; i++) begin
            put(act_word(seed, i, 0), act_word(seed, i, 1),
                act_word(seed, i, 2), act_word(seed, i, 3), 1'b1);
            if (i == 1) expect_now(last_ey, last_ec, 1'b0, v, f, {req, " R6 hold mid-line"});
        end
        put_same(10'h3FF, 1'b1);
        put_same(10'h000, 1'b1);
        put_same(10'h000, 1'b1);
        put_same(xyz(f, v, 1'b1), 1'b1);
        put_same({1'b1, 7'(seed), 2'b00}, 1'b1);
        put_same(10'h200, 1'b1);
        for (int k = 0; k < 4; k++) begin
            cw0[k] = {~bcrc[k][8],  bcrc[k][8:0]};
            cw1[k] = {~bcrc[k][17], bcrc[k][17:9]};
            if (flip9) begin
                cw0[k][9] = ~cw0[k][9];
                cw1[k][9] = ~cw1[k][9];
            end
            if (bad[k]) cw1[k][3] = ~cw1[k][3];
        end
        put(cw0[0], cw0[1], cw0[2], cw0[3], 1'b0);
        put(cw1[0], cw1[1], cw1[2], cw1[3], 1'b0);
        if (dual_link) begin
            ey = {bad[0], bad[2]};
            ec = {bad[1], bad[3]};
        end else begin
            ey = {1'b0, bad[0]};
            ec = {1'b0, bad[1]};
        end
        expect_now(ey, ec, 1'b1, v, f, req);
        last_ey = ey;
        last_ec = ec;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R7: reset state
        #1;
        n_cmp++;
        if ({crc_err_y, crc_err_c, hblank, vblank, field} !== 7'b0) begin
            n_bad++;
            $display("FAIL R7 reset: got %b expected 0000000",
                     {crc_err_y, crc_err_c, hblank, vblank, field});
        end
        do_reset(1'b0);

        // R7: end marker with a wrong CRC before any start marker leaves flags low
        for (int i = 0; i < 3; i++) put(10'h040, 10'h200, 10'h040, 10'h200, 1'b0);
        put_same(10'h3FF, 1'b0);
        put_same(10'h000, 1'b0);
        put_same(10'h000, 1'b0);
        put_same(xyz(1'b0, 1'b0, 1'b1), 1'b0);
        put_same(10'h204, 1'b0);
        put_same(10'h200, 1'b0);
        put_same(10'h155, 1'b0);
        put_same(10'h2AA, 1'b0);
        expect_now(2'b00, 2'b00, 1'b1, 1'b0, 1'b0, "R7 unprimed");

        // R1 R3 R4 R8: clean line
        send_line(12, 3, 1'b0, 1'b0, 4'b0000, 1'b0, "R3 clean line");
        // R5: luma only bad, then R6 hold and drop
        send_line(20, 5, 1'b0, 1'b0, 4'b0001, 1'b0, "R5 luma bad");
        send_line(9,  7, 1'b0, 1'b0, 4'b0000, 1'b0, "R6 drop after good");
        // R5: both bad
        send_line(16, 9, 1'b0, 1'b0, 4'b0011, 1'b0, "R5 both bad");
        send_line(16, 11, 1'b0, 1'b0, 4'b0010, 1'b0, "R5 chroma only");
        // R4: bit 9 of CRC words ignored
        send_line(14, 13, 1'b0, 1'b0, 4'b0000, 1'b1, "R4 bit9 ignored");
        // R2: vertical blanking and field bits
        send_line(6, 15, 1'b1, 1'b1, 4'b0000, 1'b0, "R2 v/f decode");
        // R1: short and long lines, one false 3FF lead-in in blanking
        send_line(3, 17, 1'b0, 1'b0, 4'b0001, 1'b0, "R1 short line");
        put_same(10'h3FF, 1'b0);
        put_same(10'h100, 1'b0);
        send_line(40, 19, 1'b0, 1'b0, 4'b0000, 1'b0, "R1 false lead-in");

        // R9: dual link
        do_reset(1'b1);
        send_line(10, 21, 1'b0, 1'b0, 4'b0000, 1'b0, "R9 dual clean");
        send_line(10, 23, 1'b0, 1'b0, 4'b1001, 1'b0, "R9 A-luma B-chroma bad");
        send_line(12, 25, 1'b0, 1'b0, 4'b0110, 1'b0, "R9 A-chroma B-luma bad");
        send_line(8,  27, 1'b0, 1'b0, 4'b0000, 1'b0, "R9 R6 dual drop");

        // R8: back to single, bit 1 stays low
        do_reset(1'b0);
        send_line(10, 29, 1'b0, 1'b0, 4'b0011, 1'b0, "R8 single mapping");

        repeat (4) @(posedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule